// File: doc/BRIEF.md
# Peak-Hold Register with Host Write Semantics

This block keeps the largest value seen on a 16-bit measurement stream belonging to one monitored quantity: an output voltage, an output current or a die temperature. The `chan_kind` input names the quantity. Each accepted sample is compared against the stored peak, and the stored peak is replaced only when the sample is strictly larger. Voltage and current samples are compared as unsigned magnitudes. Temperature samples are compared as signed two's-complement values.

A host can read the stored peak at any time on `peak_val`. A host write has two uses. It can reset the peak to the lowest value for the channel. It can also load a threshold, which then acts as the baseline that later samples must exceed. The reset code depends on the channel:

- On the voltage and current channels, writing zero clears the peak to zero.
- On the temperature channel, writing all-ones drops the peak to the most negative signed value.
- Any other written word is stored unchanged.

The block contains an averager that is used when averaging is enabled and the channel is voltage. In that case the tracker sees one mean per group of 2^`AVG_LOG2` samples instead of each raw sample.

Top module: `peak_hold_reg`

## Requirements
- R1: On the voltage and current channels (`chan_kind` 0 and 1), an accepted sample replaces the peak only if it is strictly greater as an unsigned number. An equal or smaller sample leaves the peak unchanged.
- R2: On the voltage and current channels, a host write of 0x0000 sets the peak to 0x0000.
- R3: On the temperature channel (`chan_kind` 2), a host write of 0xFFFF sets the peak to 0x8000, the most negative signed value.
- R4: Any other host write stores the written word as the new peak. This includes 0xFFFF on the voltage channel and 0x0000 on the temperature channel. Later samples must exceed that word to replace it.
- R5: On the temperature channel, samples are compared as signed two's-complement values. For example, 0xFF00 does not replace 0x0010, but 0xFFF0 does replace 0x8000.
- R6: When `filt_en` is 1 and the channel is voltage, raw samples do not reach the tracker. Every 2^`AVG_LOG2` accepted samples (4 by default) produce their truncated mean. That mean is offered to the tracker one cycle after the last sample of the group is accepted.
- R7: `filt_en` has no effect on the current and temperature channels. Their samples are offered to the tracker directly.
- R8: While `rst_n` is low at a clock edge, the peak becomes 0x0000 and any partial average is discarded.
- R9: If a host write and an offered sample occur in the same cycle, the host write decides the new peak.
- R10: An unfiltered sample or a host write presented at a rising edge is visible on `peak_val` immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_vld | input | 1 | Measurement sample strobe |
| smp_val | input | DW | Measurement sample value |
| host_wr | input | 1 | Host write strobe |
| host_data | input | DW | Host write data |
| chan_kind | input | 2 | Channel type: 0 voltage, 1 current, 2 temperature |
| filt_en | input | 1 | Enables averaging on the voltage channel |
| peak_val | output | DW | Held peak value |

## Verification
The bench drives each stimulus on a falling edge, so it is captured at the next rising edge. A host write or an unfiltered sample then appears on `peak_val` after that one rising edge, and the bench samples it on the following falling edge. The averaged path has one extra register. After the last sample of a group is captured, the bench checks at the first falling edge that `peak_val` has not yet moved, and checks one cycle later that it holds the mean. Reset is checked on the falling edge after a rising edge with `rst_n` low.

// File: rtl/peak_hold_pkg.sv
package peak_hold_pkg;
   typedef enum logic [1:0] {
      CH_VOLT = 2'd0,
      CH_CURR = 2'd1,
      CH_TEMP = 2'd2,
      CH_RSVD = 2'd3
   } chan_kind_e;
endpackage

// File: rtl/peak_hold_avg.sv
module peak_hold_avg #(
   parameter int DW       = 16,
   parameter int AVG_LOG2 = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          in_vld,
   input  logic [DW-1:0] in_val,
   output logic          out_vld,
   output logic [DW-1:0] out_val
);
   if (AVG_LOG2 == 0) begin : g_pass
      assign out_vld = in_vld;
      assign out_val = in_val;
   end else begin : g_acc
      localparam int AW = DW + AVG_LOG2;
      localparam logic [AVG_LOG2-1:0] CNT_ONE  = 1;
      localparam logic [AVG_LOG2-1:0] CNT_LAST = '1;

      logic [AVG_LOG2-1:0] cnt_q;
      logic [AW-1:0]       acc_q;
      logic [AW-1:0]       sum_d;
      logic                vld_q;
      logic [DW-1:0]       val_q;

      assign sum_d = acc_q + {{AVG_LOG2{1'b0}}, in_val};

      always_ff @(posedge clk) begin
         if (!rst_n || !en) begin
            cnt_q <= '0;
            acc_q <= '0;
            vld_q <= 1'b0;
            val_q <= '0;
         end else begin
            vld_q <= 1'b0;
            if (in_vld) begin
               if (cnt_q == CNT_LAST) begin
                  val_q <= sum_d[AW-1:AVG_LOG2];
                  vld_q <= 1'b1;
                  acc_q <= '0;
                  cnt_q <= '0;
               end else begin
                  acc_q <= sum_d;
                  cnt_q <= cnt_q + CNT_ONE;
               end
            end
         end
      end

      assign out_vld = vld_q;
      assign out_val = val_q;
   end
endmodule

// File: rtl/peak_hold_cmp.sv
module peak_hold_cmp #(
   parameter int DW = 16
) (
   input  logic          is_signed,
   input  logic [DW-1:0] cand,
   input  logic [DW-1:0] held,
   output logic          greater
);
   logic gt_u;
   logic gt_s;

   assign gt_u    = cand > held;
   assign gt_s    = $signed(cand) > $signed(held);
   assign greater = is_signed ? gt_s : gt_u;
endmodule

// File: rtl/peak_hold_reg.sv
module peak_hold_reg
   import peak_hold_pkg::*;
#(
   parameter int DW       = 16,
   parameter int AVG_LOG2 = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_vld,
   input  logic [DW-1:0] smp_val,
   input  logic          host_wr,
   input  logic [DW-1:0] host_data,
   input  logic [1:0]    chan_kind,
   input  logic          filt_en,
   output logic [DW-1:0] peak_val
);
   localparam logic [DW-1:0] FLOOR_S = {1'b1, {(DW-1){1'b0}}};
   localparam logic [DW-1:0] CLR_T   = '1;

   if (DW < 4) begin : g_bad_dw
      $error("peak_hold_reg: DW must be at least 4");
   end
   if (AVG_LOG2 < 0 || AVG_LOG2 > 8) begin : g_bad_avg
      $error("peak_hold_reg: AVG_LOG2 must be within 0..8");
   end

   logic          is_temp;
   logic          filt_act;
   logic          avg_vld;
   logic [DW-1:0] avg_val;
   logic          ofr_vld;
   logic [DW-1:0] ofr_val;
   logic          ofr_gt;
   logic [DW-1:0] peak_q;

   assign is_temp  = (chan_kind == CH_TEMP);
   assign filt_act = filt_en && (chan_kind == CH_VOLT);

   peak_hold_avg #(.DW(DW), .AVG_LOG2(AVG_LOG2)) u_avg (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (filt_act),
      .in_vld  (smp_vld),
      .in_val  (smp_val),
      .out_vld (avg_vld),
      .out_val (avg_val)
   );

   assign ofr_vld = filt_act ? avg_vld : smp_vld;
   assign ofr_val = filt_act ? avg_val : smp_val;

   peak_hold_cmp #(.DW(DW)) u_cmp (
      .is_signed (is_temp),
      .cand      (ofr_val),
      .held      (peak_q),
      .greater   (ofr_gt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         peak_q <= '0;
      end else if (host_wr) begin
         peak_q <= (is_temp && host_data == CLR_T) ? FLOOR_S : host_data;
      end else if (ofr_vld && ofr_gt) begin
         peak_q <= ofr_val;
      end
   end

   assign peak_val = peak_q;
endmodule

// File: rtl/peak_hold_reg_chk.sv
module peak_hold_reg_chk #(
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          host_wr,
   input logic [DW-1:0] host_data,
   input logic [1:0]    chan_kind,
   input logic          ofr_vld,
   input logic [DW-1:0] ofr_val,
   input logic [DW-1:0] peak_val
);
   localparam logic [DW-1:0] ONES = '1;
   localparam logic [DW-1:0] MINS = {1'b1, {(DW-1){1'b0}}};

   // R8
   reset_clears_chk: assert property (@(posedge clk)
      !rst_n |=> peak_val == '0);

   // R1
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && !ofr_vld) |=> $stable(peak_val));

   // R1
   unsigned_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && chan_kind != 2'd2) |=> peak_val >= $past(peak_val));

   // R5
   signed_no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && chan_kind == 2'd2) |=> $signed(peak_val) >= $signed($past(peak_val)));

   // R3
   temp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && chan_kind == 2'd2 && host_data == ONES) |=> peak_val == MINS);

   // R4 R9
   write_seed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !(chan_kind == 2'd2 && host_data == ONES)) |=> peak_val == $past(host_data));

   // R1
   take_larger_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_wr && ofr_vld && chan_kind != 2'd2 && ofr_val > peak_val) |=> peak_val == $past(ofr_val));
endmodule

bind peak_hold_reg peak_hold_reg_chk #(.DW(DW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .host_wr   (host_wr),
   .host_data (host_data),
   .chan_kind (chan_kind),
   .ofr_vld   (ofr_vld),
   .ofr_val   (ofr_val),
   .peak_val  (peak_val)
);

// File: tb/peak_hold_reg_bench.sv
`timescale 1ns/1ps
module peak_hold_reg_bench;
   localparam int DW = 16;
   localparam int NV = 21;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_vld = 1'b0;
   logic [DW-1:0] smp_val = '0;
   logic          host_wr = 1'b0;
   logic [DW-1:0] host_data = '0;
   logic [1:0]    chan_kind = 2'd0;
   logic          filt_en = 1'b0;
   logic [DW-1:0] peak_val;

   int n_run = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   peak_hold_reg #(.DW(DW), .AVG_LOG2(2)) u_peak_hold_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_vld   (smp_vld),
      .smp_val   (smp_val),
      .host_wr   (host_wr),
      .host_data (host_data),
      .chan_kind (chan_kind),
      .filt_en   (filt_en),
      .peak_val  (peak_val)
   );

   // Vector fields: kind(2) wr(1) wdata(16) vld(1) val(16) expected peak(16)
   localparam logic [51:0] VEC [NV] = '{
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'h0100, 16'h0100},  // R1 R10
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'h00FF, 16'h0100},  // R1 smaller
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'h0100, 16'h0100},  // R1 equal
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'hF000, 16'hF000},  // R1 unsigned
      {2'd0, 1'b1, 16'h0000, 1'b0, 16'h0000, 16'h0000},  // R2
      {2'd0, 1'b1, 16'h0500, 1'b0, 16'h0000, 16'h0500},  // R4 seed
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'h0400, 16'h0500},  // R4 below seed
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'h0501, 16'h0501},  // R4 above seed
      {2'd1, 1'b1, 16'h0000, 1'b0, 16'h0000, 16'h0000},  // R2 current
      {2'd1, 1'b0, 16'h0000, 1'b1, 16'h8000, 16'h8000},  // R1 current
      {2'd2, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 16'h8000},  // R3
      {2'd2, 1'b0, 16'h0000, 1'b1, 16'hFFF0, 16'hFFF0},  // R5
      {2'd2, 1'b0, 16'h0000, 1'b1, 16'h0010, 16'h0010},  // R5
      {2'd2, 1'b0, 16'h0000, 1'b1, 16'hFF00, 16'h0010},  // R5 negative
      {2'd2, 1'b1, 16'h0020, 1'b0, 16'h0000, 16'h0020},  // R4 temp seed
      {2'd2, 1'b0, 16'h0000, 1'b1, 16'h001F, 16'h0020},  // R4
      {2'd2, 1'b1, 16'h0000, 1'b0, 16'h0000, 16'h0000},  // R4 zero on temp
      {2'd2, 1'b0, 16'h0000, 1'b1, 16'hFFFF, 16'h0000},  // R5 minus one
      {2'd0, 1'b1, 16'hFFFF, 1'b0, 16'h0000, 16'hFFFF},  // R4 ones on volt
      {2'd0, 1'b0, 16'h0000, 1'b1, 16'hFFFE, 16'hFFFF},  // R1
      {2'd0, 1'b1, 16'h0010, 1'b1, 16'h9000, 16'h0010}   // R9
   };

   task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      n_run++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: peak_val=%h expected %h", req, got, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
         $finish;
      end
   endtask

   // one stimulus cycle: drive at negedge, sample at the next negedge
   task automatic step(input logic [1:0] k, input logic w, input logic [DW-1:0] wd,
                       input logic v, input logic [DW-1:0] sv);
      chan_kind = k;
      host_wr   = w;
      host_data = wd;
      smp_vld   = v;
      smp_val   = sv;
      @(negedge clk);
      host_wr = 1'b0;
      smp_vld = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check("R8 reset", peak_val, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][51:50], VEC[i][49], VEC[i][48:33], VEC[i][32], VEC[i][31:16]);
         check($sformatf("vector %0d (R1..R5 R9 R10)", i), peak_val, VEC[i][15:0]);
      end

      // R6: averaged voltage path
      step(2'd0, 1'b1, 16'h0000, 1'b0, 16'h0000);
      filt_en = 1'b1;
      step(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0100);
      step(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0200);
      check("R6 raw sample blocked", peak_val, 16'h0000);
      step(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0300);
      step(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0401);
      check("R6 mean not yet due", peak_val, 16'h0000);
      @(negedge clk);
      check("R6 mean 0x0280", peak_val, 16'h0280);

      // R7: filter ignored on temperature and current
      step(2'd2, 1'b1, 16'hFFFF, 1'b0, 16'h0000);
      step(2'd2, 1'b0, 16'h0000, 1'b1, 16'h0005);
      check("R7 temp unfiltered", peak_val, 16'h0005);
      step(2'd1, 1'b1, 16'h0000, 1'b0, 16'h0000);
      step(2'd1, 1'b0, 16'h0000, 1'b1, 16'h0033);
      check("R7 current unfiltered", peak_val, 16'h0033);
      filt_en = 1'b0;

      // R8: reset in mid run
      rst_n = 1'b0;
      @(negedge clk);
      check("R8 reset mid run", peak_val, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);

      finish_run();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_run++;
      n_bad++;
      $display("FAIL watchdog: peak_val=%h expected run to end", peak_val);
      finish_run();
   end
endmodule